// File: doc/BRIEF.md
# DMA Channel Register Controller

This block keeps the programming state of a set of DMA channels and decides, one request at a time, whether a device's transfer request may proceed. Every channel owns four 32-bit words: a spare mode word, a control/status word, a remaining byte count and a memory address. Software reaches all of them, plus a shared error-source word, through a simple word-wide register port. Reads are combinational and writes take effect at the clock edge.

A device asks for a transfer by presenting a channel number, a direction and a length on a valid/ready handshake. The block first wipes the channel's status flags. It then checks that the channel is enabled and programmed for the same direction. If the check passes, the block clamps the length to the bytes left and reduces the count. If it fails, the block marks a memory error and records the channel in the shared error-source word. One cycle later it pulses a grant that carries the length, the address and an error flag, for an external data mover that does the copy.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every channel word, the error-source word and `gnt_valid` are zero, and `req_ready` is high while no register write is presented.
- R2: Channel c, word k (k = 0 mode, 1 control, 2 count, 3 address) sits at byte address 0x100 + c*0x20 + k*8. Address bits [2:0] are ignored. A write stores the full 32 bits and a read returns them. The error-source word reads at 0x200, zero-extended. All other addresses read as zero.
- R3: `req_ready` is low in any cycle where `reg_wr` is high. A request is accepted only in a cycle with `req_valid` and `req_ready` both high. A request held during a write is not accepted and produces no grant.
- R4: Each accepted request produces exactly one `gnt_valid` pulse, in the cycle after acceptance. `gnt_valid` is low in every other cycle.
- R5: A request is refused when control bit 0 (enable) is clear, or when `req_to_dev` differs from control bit 1 (1 = memory-to-device, 0 = device-to-memory). A refused request grants with `gnt_err`=1, `gnt_len`=0 and `gnt_addr`=0. It sets control bit 9, sets bit c of the error-source word and leaves the count unchanged.
- R6: An accepted, consistent request grants `gnt_err`=0 and `gnt_len` = min(`req_len`, count), with `gnt_addr` equal to the channel's address word. It sets control bit 8 and lowers the count by `gnt_len`. The address word is not changed.
- R7: Every accepted request clears control bits 8, 9 and 10 before it sets its own flag. Afterwards exactly one of bits 8 and 9 is set and bit 10 is clear. All other control bits are kept.
- R8: Error-source bits are sticky. A register write of zero to 0x200 clears them all, and a write of any non-zero value leaves them unchanged.
- R9: A request to channel c changes no word of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_chan | input | $clog2(N_CH) | Requesting channel |
| req_to_dev | input | 1 | 1 = memory-to-device, 0 = device-to-memory |
| req_len | input | 32 | Requested byte length |
| gnt_valid | output | 1 | One-cycle grant pulse |
| gnt_len | output | 32 | Granted byte length |
| gnt_addr | output | 32 | Granted memory address |
| gnt_err | output | 1 | Request was refused |

## Verification
Some properties are checked on every cycle. The grant pulse must follow each acceptance and appear at no other time. A refusal must carry an empty grant and light its channel's error-source bit. A consistent grant may never exceed the count or the requested length, and it must use the stored address. Control flags end each request with exactly one of terminal-count and memory-error set. Error-source bits never drop without a clearing write. Only the bench scenarios can show the full picture: the exact register contents after mixed writes and requests, the untouched state of other channels, the stalling of requests behind register writes, the way a non-zero write to the error-source word is ignored, and the clamp at zero count and at an exact match.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;
  localparam int DATA_W = 32;
  typedef logic [DATA_W-1:0] word_t;

  localparam logic [1:0] IDX_MODE  = 2'd0;
  localparam logic [1:0] IDX_CTRL  = 2'd1;
  localparam logic [1:0] IDX_COUNT = 2'd2;
  localparam logic [1:0] IDX_ADDR  = 2'd3;

  localparam int B_EN    = 0;
  localparam int B_TODEV = 1;
  localparam int B_TC    = 8;
  localparam int B_MERR  = 9;
  localparam int B_AERR  = 10;

  function automatic word_t clamp_len(word_t want, word_t left);
    return (want < left) ? want : left;
  endfunction

  function automatic logic chan_ok(word_t ctrl, logic to_dev);
    return ctrl[B_EN] && (ctrl[B_TODEV] == to_dev);
  endfunction

  function automatic word_t ctrl_after(word_t ctrl, logic ok);
    word_t c;
    c         = ctrl;
    c[B_AERR] = 1'b0;
    c[B_TC]   = ok;
    c[B_MERR] = !ok;
    return c;
  endfunction
endpackage

// File: rtl/dmacr_chan.sv
module dmacr_chan
  import dmacr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_idx,
  input  word_t            wr_data,
  input  logic             upd_en,
  input  logic             upd_ok,
  input  word_t            upd_len,
  output logic [3:0][DATA_W-1:0] regs_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q[wr_idx] <= wr_data;
    end else if (upd_en) begin
      regs_q[IDX_CTRL] <= ctrl_after(regs_q[IDX_CTRL], upd_ok);
      if (upd_ok) regs_q[IDX_COUNT] <= regs_q[IDX_COUNT] - upd_len;
    end
  end

  // R7: after an update exactly one of the two outcome flags stands
  assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_en) |=> ((regs_q[IDX_CTRL][B_TC] ^ regs_q[IDX_CTRL][B_MERR])
                            && !regs_q[IDX_CTRL][B_AERR]));

  // R6: a consistent update never grows the count
  assert_count_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_ok && !wr_en) |=> (regs_q[IDX_COUNT] <= $past(regs_q[IDX_COUNT])));
endmodule

// File: rtl/dmacr_eval.sv
module dmacr_eval
  import dmacr_pkg::*;
(
  input  word_t ctrl,
  input  word_t count,
  input  word_t addr,
  input  logic  to_dev,
  input  word_t want_len,
  output logic  ok,
  output word_t len_out,
  output word_t addr_out
);
  always_comb begin
    ok       = chan_ok(ctrl, to_dev);
    len_out  = ok ? clamp_len(want_len, count) : '0;
    addr_out = ok ? addr : '0;
  end
endmodule

// File: rtl/dmacr_errsrc.sv
module dmacr_errsrc #(
  parameter int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            set_en,
  input  logic [CH_W-1:0] set_ch,
  output logic [N_CH-1:0] bits_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      bits_q <= '0;
    else if (clr)    bits_q <= '0;
    else if (set_en) bits_q <= bits_q | (N_CH'(1) << set_ch);
  end

  // R8: no bit falls without a clearing write
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((bits_q & $past(bits_q)) == $past(bits_q)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmacr_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int ADDR_W   = 10,
  parameter int CH_BASE  = 256,
  parameter int ERR_ADDR = 512,
  localparam int CH_W    = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic              req_to_dev,
  input  logic [DATA_W-1:0] req_len,
  output logic              gnt_valid,
  output logic [DATA_W-1:0] gnt_len,
  output logic [DATA_W-1:0] gnt_addr,
  output logic              gnt_err
);
  localparam int WIN_BYTES = N_CH * 32;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] ERR_A  = ADDR_W'(ERR_ADDR);

  // register port decode
  logic [ADDR_W-1:0] win_off;
  logic              in_win, is_err;
  logic [CH_W-1:0]   win_ch;
  logic [1:0]        win_idx;

  assign win_off = reg_addr - BASE_A;
  assign in_win  = (int'(reg_addr) >= CH_BASE) && (int'(reg_addr) < CH_BASE + WIN_BYTES);
  assign win_ch  = win_off[CH_W+4:5];
  assign win_idx = win_off[4:3];
  assign is_err  = (reg_addr[ADDR_W-1:3] == ERR_A[ADDR_W-1:3]);

  // request side events
  logic  accept, eval_ok, err_clr;
  word_t eval_len, eval_addr;
  logic [N_CH-1:0][3:0][DATA_W-1:0] chan_regs;
  logic [3:0][DATA_W-1:0]           sel_regs;
  logic [N_CH-1:0]                  err_bits;

  assign req_ready = !reg_wr;
  assign accept    = req_valid && req_ready;
  assign sel_regs  = chan_regs[req_chan];
  assign err_clr   = reg_wr && is_err && (reg_wdata == '0);

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    dmacr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr && in_win && (win_ch == CH_W'(g))),
      .wr_idx  (win_idx),
      .wr_data (reg_wdata),
      .upd_en  (accept && (req_chan == CH_W'(g))),
      .upd_ok  (eval_ok),
      .upd_len (eval_len),
      .regs_q  (chan_regs[g])
    );
  end

  dmacr_eval u_eval (
    .ctrl     (sel_regs[IDX_CTRL]),
    .count    (sel_regs[IDX_COUNT]),
    .addr     (sel_regs[IDX_ADDR]),
    .to_dev   (req_to_dev),
    .want_len (req_len),
    .ok       (eval_ok),
    .len_out  (eval_len),
    .addr_out (eval_addr)
  );

  dmacr_errsrc #(.N_CH(N_CH)) u_errsrc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (err_clr),
    .set_en (accept && !eval_ok),
    .set_ch (req_chan),
    .bits_q (err_bits)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_win)      reg_rdata = chan_regs[win_ch][win_idx];
    else if (is_err) reg_rdata = DATA_W'(err_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_len   <= '0;
      gnt_addr  <= '0;
      gnt_err   <= 1'b0;
    end else begin
      gnt_valid <= accept;
      if (accept) begin
        gnt_len  <= eval_len;
        gnt_addr <= eval_addr;
        gnt_err  <= !eval_ok;
      end
    end
  end

  // R4: one grant pulse per acceptance, in the following cycle
  assert_grant_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> gnt_valid);
  assert_no_stray_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !gnt_valid);

  // R5: a refusal grants nothing and marks its channel
  assert_refusal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !eval_ok) |=> (gnt_err && gnt_len == '0 && gnt_addr == '0
                              && err_bits[$past(req_chan)]));

  // R6: a consistent grant is bounded and uses the stored address
  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && eval_ok) |=> (!gnt_err && gnt_len <= $past(sel_regs[IDX_COUNT])
                             && gnt_len <= $past(req_len)
                             && gnt_addr == $past(sel_regs[IDX_ADDR])));
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_chan = '0;
  logic        req_to_dev = 1'b0;
  logic [31:0] req_len = '0;
  logic        gnt_valid;
  logic [31:0] gnt_len, gnt_addr;
  logic        gnt_err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_regs [NCH][4];
  logic [7:0]  m_err;

  always #2.5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_to_dev(req_to_dev),
    .req_len(req_len), .gnt_valid(gnt_valid), .gnt_len(gnt_len),
    .gnt_addr(gnt_addr), .gnt_err(gnt_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] ch_addr(int c, int k);
    return 10'(256 + c * 32 + k * 8);
  endfunction

  function automatic logic [31:0] exp_len(logic [31:0] want, logic [31:0] left);
    if (left < want) return left;
    return want;
  endfunction

  function automatic logic exp_ok(logic [31:0] ctrl, logic dir);
    return (ctrl[0] == 1'b1) && (ctrl[1] == dir);
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (int'(a) >= 256 && int'(a) < 512) m_regs[(int'(a) - 256) / 32][(int'(a) / 8) % 4] = d;
    if (a[9:3] == 7'h40 && d == 32'd0) m_err = '0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, $sformatf("read @%h", a), reg_rdata, exp);
  endtask

  task automatic readback_all(input string req);
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++) rd(ch_addr(c, k), m_regs[c][k], req);
    rd(10'h200, {24'd0, m_err}, req);
  endtask

  task automatic do_req(input int c, input logic dir, input logic [31:0] len);
    logic        ok;
    logic [31:0] el, ea, ctl;
    ok  = exp_ok(m_regs[c][1], dir);
    el  = ok ? exp_len(len, m_regs[c][2]) : 32'd0;
    ea  = ok ? m_regs[c][3] : 32'd0;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'(c); req_to_dev = dir; req_len = len;
    #1;
    chk("R3", "ready without write", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4", "grant pulse", {31'd0, gnt_valid}, 32'd1);
    chk("R5", "grant error flag", {31'd0, gnt_err}, {31'd0, !ok});
    chk("R6", "grant length", gnt_len, el);
    chk("R6", "grant address", gnt_addr, ea);
    ctl = m_regs[c][1];
    ctl[10] = 1'b0; ctl[8] = ok; ctl[9] = !ok;
    m_regs[c][1] = ctl;
    if (ok) m_regs[c][2] = m_regs[c][2] - el;
    else    m_err[c] = 1'b1;
    @(negedge clk);
    chk("R4", "grant drops", {31'd0, gnt_valid}, 32'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < NCH; c++) for (int k = 0; k < 4; k++) m_regs[c][k] = '0;
    m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "gnt_valid after reset", {31'd0, gnt_valid}, 32'd0);
    chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);
    readback_all("R1");

    // R2 map and unmapped reads
    for (int k = 0; k < 4; k++) wr(ch_addr(3, k), 32'hA5000000 | 32'(k));
    wr(ch_addr(7, 3) | 10'd5, 32'h1234_5678);
    for (int k = 0; k < 4; k++) rd(ch_addr(3, k) | 10'd2, m_regs[3][k], "R2");
    rd(ch_addr(7, 3), 32'h1234_5678, "R2");
    rd(10'h000, 32'd0, "R2");
    rd(10'h0F8, 32'd0, "R2");
    rd(10'h208, 32'd0, "R2");

    // R5 disabled channel
    do_req(2, 1'b0, 32'd16);
    rd(ch_addr(2, 1), 32'h0000_0200, "R5");
    rd(ch_addr(2, 2), 32'd0, "R5");
    rd(10'h200, 32'h0000_0004, "R5");

    // R6 clamp sequence, R7 flag clearing
    wr(ch_addr(1, 1), 32'h0000_0703);
    wr(ch_addr(1, 2), 32'd100);
    wr(ch_addr(1, 3), 32'h0000_ABC0);
    do_req(1, 1'b1, 32'd40);
    rd(ch_addr(1, 1), 32'h0000_0103, "R7");
    rd(ch_addr(1, 2), 32'd60, "R6");
    do_req(1, 1'b1, 32'd100);
    rd(ch_addr(1, 2), 32'd0, "R6");
    do_req(1, 1'b1, 32'd5);
    do_req(1, 1'b0, 32'd5);
    rd(ch_addr(1, 1), 32'h0000_0203, "R5");
    rd(ch_addr(1, 3), 32'h0000_ABC0, "R6");
    wr(ch_addr(4, 1), 32'h1);
    wr(ch_addr(4, 2), 32'd77);
    do_req(4, 1'b0, 32'd77);
    rd(ch_addr(4, 2), 32'd0, "R6");
    readback_all("R9");

    // R3 request held during a register write
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ch_addr(5, 0); reg_wdata = 32'h55;
    req_valid = 1'b1; req_chan = 3'd5; req_to_dev = 1'b0; req_len = 32'd1;
    #1;
    chk("R3", "ready low during write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0;
    m_regs[5][0] = 32'h55;
    chk("R3", "no grant after stalled request", {31'd0, gnt_valid}, 32'd0);
    rd(10'h200, {24'd0, m_err}, "R3");

    // R8 sticky error source
    wr(10'h200, 32'hFF);
    rd(10'h200, {24'd0, m_err}, "R8");
    wr(10'h200, 32'd0);
    rd(10'h200, 32'd0, "R8");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op, c;
      logic [31:0] v;
      op = int'($urandom_range(0, 9));
      c  = int'($urandom_range(0, NCH - 1));
      if (op < 3) begin
        v = $urandom;
        v[0] = ($urandom_range(0, 3) != 0);
        wr(ch_addr(c, 1), v);
      end else if (op == 3) begin
        wr(ch_addr(c, 2), 32'($urandom_range(0, 500)));
      end else if (op == 4) begin
        wr(ch_addr(c, int'($urandom_range(0, 1)) * 3), $urandom);
      end else if (op == 5 && $urandom_range(0, 5) == 0) begin
        wr(10'h200, ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom);
      end else begin
        do_req(c, 1'($urandom_range(0, 1)), 32'($urandom_range(0, 600)));
      end
      if (it % 40 == 39) readback_all("R9");
    end
    readback_all("R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule